// File: doc/BRIEF.md
# Sound Control Register Bank

This block holds the byte-wide control registers of a four-channel sound unit and sits on a simple processor bus. The bus has an address, write data, a write strobe and a read-data return. A master power bit decides whether the per-channel and mixer registers accept writes. While power is off, a write normally stores zero. A legacy-model parameter keeps some length fields writable with power off. Turning power off clears every channel and mixer register.

Reads come back one clock after the address is presented. Each register ORs its own fixed mask into the read value, so bits that are unused or write-only read as 1. The master register reads back the power bit together with four channel-active flags. Those flags come from the channel logic and are sampled on the clock. The raw register contents go out on one flat bus to the tone, wave and noise generators, which are outside this block.

Register map (index = bus address): 0 ch1 sweep, 1 ch1 length/duty, 2 ch1 envelope, 3 ch1 period low, 4 ch1 period high/trigger, 5 ch2 length/duty, 6 ch2 envelope, 7 ch2 period low, 8 ch2 period high/trigger, 9 ch3 DAC enable, 10 ch3 length, 11 ch3 level, 12 ch3 period low, 13 ch3 period high/trigger, 14 ch4 length, 15 ch4 envelope, 16 ch4 polynomial, 17 ch4 control, 18 master volume, 19 panning, 20 master control. Addresses 21 and above are not implemented.

Top module: `snd_ctl_bank`

## Requirements
- R1: Reset is synchronous and active-low.
  - After reset the stored bytes are 0x80, 0xBF, 0xF3, 0xF3, 0xBF (indices 0..4), 0x3F, 0x00, 0x00, 0xBF (5..8), 0x7F, 0xFF, 0x9F, 0x00, 0xBF (9..13), 0xFF, 0x00, 0x00, 0xBF (14..17), 0x77, 0xF3 (18..19).
  - Power is on after reset.
  - The read-data register resets to 0xFF.
- R2: While power is on, a write to index 0..19 stores the written byte unchanged.
- R3: A read of index 0..19 returns the stored byte ORed with that index's mask:
  - sweep 0x80;
  - both length/duty registers 0x3F;
  - all period-low registers, the ch3 length and the ch4 length 0xFF;
  - all period-high/trigger registers and the ch4 control 0xBF;
  - DAC enable 0x7F;
  - level 0x9F;
  - all others 0x00.
- R4: While power is off, a write to index 0..19 stores 0x00, except for the cases in R5 and R6.
- R5: In legacy mode with power off, a write to index 1 or 5 stores the written byte ANDed with 0x3F.
- R6: With power off, a write to index 10 or 14 stores the full byte in legacy mode and stores 0x00 in enhanced mode.
- R7: The master control register (index 20) works as follows:
  - A write sets the power bit from data bit 7 and ignores the other data bits.
  - A read returns the power bit in bit 7, 1s in bits 6:4, and the channel-active inputs in bits 3:0.
- R8: A master write with data bit 7 = 0 sets indices 0..19 to 0x00 at that same clock edge.
- R9: A read of address 21 or above returns 0xFF. A write to such an address changes no stored byte.
- R10: Read data reflects the address presented before the rising edge that loads the read register.
  - The channel-active inputs pass through one sampling register before the read register.
  - A change on those inputs therefore shows on a master read two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register index for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| chan_active | input | 4 | Channel-active flags from the channel logic |
| bus_rdata | output | 8 | Registered read data |
| cfg_flat | output | 160 | Raw stored bytes, index i at bits 8i+7:8i |

## Verification
A write takes effect at the rising edge where the strobe is high. That includes the clear caused by switching power off, so the flat configuration bus is checked at the next falling edge. A read address placed at a falling edge produces read data after the following rising edge. The driver therefore queues each expected byte tagged with a due cycle one past the current count, and the monitor compares only at the falling edge where that count is reached. The status path has one more register. The bench changes the channel flags with the address held and expects the old flags at the first due edge and the new flags at the second. A legacy instance and an enhanced instance share all stimulus, so the power-off exemptions are compared side by side.

// File: rtl/snd_pkg.sv
// Package: shared constants and per-index tables for the sound control bank.
// Assumes the index layout listed in the brief; tables are computed by case.
package snd_pkg;
    localparam int N_CH_REG   = 20;          // channel + mixer registers
    localparam int MASTER_IDX = 20;          // master control index
    localparam int N_IMPL     = 21;          // implemented indices
    localparam int CFG_W      = N_CH_REG * 8;
    localparam logic [7:0] MASTER_MASK = 8'h70;

    // Power-on value of a channel/mixer register
    function automatic logic [7:0] reg_rst(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'hBF;
            2, 3:    return 8'hF3;
            4, 8:    return 8'hBF;
            5:       return 8'h3F;
            9:       return 8'h7F;
            10, 14:  return 8'hFF;
            11:      return 8'h9F;
            13, 17:  return 8'hBF;
            18:      return 8'h77;
            19:      return 8'hF3;
            default: return 8'h00;
        endcase
    endfunction

    // Read-back OR mask of a channel/mixer register
    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            0:                   return 8'h80;
            1, 5:                return 8'h3F;
            3, 7, 10, 12, 14:    return 8'hFF;
            4, 8, 13, 17:        return 8'hBF;
            9:                   return 8'h7F;
            11:                  return 8'h9F;
            default:             return 8'h00;
        endcase
    endfunction

    // Square-channel length/duty registers
    function automatic logic is_sq_len(input int idx);
        return (idx == 1) || (idx == 5);
    endfunction

    // Wave / noise length registers
    function automatic logic is_wn_len(input int idx);
        return (idx == 10) || (idx == 14);
    endfunction
endpackage

// File: rtl/snd_write_gate.sv
// Module: decodes a bus write into per-register enables and the value to store.
// Applies the power gate and the legacy-mode length exemptions.
// Assumes one write per clock; purely combinational.
module snd_write_gate #(
    parameter int ADDR_W = 5,
    parameter bit LEGACY = 1'b1
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [7:0]                   wdata,
    input  logic                         we,
    input  logic                         pwr,
    output logic [snd_pkg::N_CH_REG-1:0] ch_we,
    output logic [7:0]                   ch_val,
    output logic                         pwr_we,
    output logic                         pwr_d,
    output logic                         clr_all
);
    import snd_pkg::*;

    logic [31:0] idx;
    assign idx = 32'(addr);

    // Per-register write enables
    always_comb begin
        for (int i = 0; i < N_CH_REG; i++) begin
            ch_we[i] = we && (idx == 32'(i));
        end
    end

    // Value stored: raw when powered, gated otherwise
    always_comb begin
        if (pwr) begin
            ch_val = wdata;
        end else if (LEGACY && is_sq_len(int'(idx))) begin
            ch_val = wdata & 8'h3F;
        end else if (LEGACY && is_wn_len(int'(idx))) begin
            ch_val = wdata;
        end else begin
            ch_val = 8'h00;
        end
    end

    // Master control decode: power bit and clear request
    always_comb begin
        pwr_we  = we && (idx == 32'(MASTER_IDX));
        pwr_d   = wdata[7];
        clr_all = pwr_we && !wdata[7];
    end
endmodule

// File: rtl/snd_reg_array.sv
// Module: storage for the channel and mixer registers.
// Each byte has its own power-on value; the clear request has priority over a write.
module snd_reg_array (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [snd_pkg::N_CH_REG-1:0] ch_we,
    input  logic [7:0]                   ch_val,
    input  logic                         clr_all,
    output logic [snd_pkg::CFG_W-1:0]    cfg_flat
);
    import snd_pkg::*;

    for (genvar g = 0; g < N_CH_REG; g++) begin : g_reg
        logic [7:0] q;
        // One byte: reset value, clear, or write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= reg_rst(g);
            end else if (clr_all) begin
                q <= 8'h00;
            end else if (ch_we[g]) begin
                q <= ch_val;
            end
        end
        assign cfg_flat[g*8 +: 8] = q;
    end
endmodule

// File: rtl/snd_read_mux.sv
// Module: selects the addressed byte, ORs in its mask and registers the result.
// Unimplemented addresses return all ones.
module snd_read_mux #(
    parameter int ADDR_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [snd_pkg::CFG_W-1:0] cfg_flat,
    input  logic                      pwr,
    input  logic [3:0]                stat,
    output logic [7:0]                rdata
);
    import snd_pkg::*;

    logic [7:0]  sel;
    logic [31:0] idx;
    assign idx = 32'(addr);

    // Read selection with per-register masks
    always_comb begin
        sel = 8'hFF;
        for (int i = 0; i < N_CH_REG; i++) begin
            if (idx == 32'(i)) begin
                sel = cfg_flat[i*8 +: 8] | reg_mask(i);
            end
        end
        if (idx == 32'(MASTER_IDX)) begin
            sel = {pwr, 3'b000, stat} | MASTER_MASK;
        end
    end

    // Read-data register, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'hFF;
        end else begin
            rdata <= sel;
        end
    end
endmodule

// File: rtl/snd_ctl_bank.sv
// Module: top of the sound control register bank.
// Holds the power bit and the sampled channel status.
// Wires the write gate, register array and read path together.
// Assumes a single synchronous clock and an active-low synchronous reset.
module snd_ctl_bank #(
    parameter int ADDR_W = 5,
    parameter bit LEGACY = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [7:0]                bus_wdata,
    input  logic                      bus_we,
    input  logic [3:0]                chan_active,
    output logic [7:0]                bus_rdata,
    output logic [snd_pkg::CFG_W-1:0] cfg_flat
);
    import snd_pkg::*;

    logic                pwr_q;
    logic [3:0]          stat_q;
    logic [N_CH_REG-1:0] ch_we;
    logic [7:0]          ch_val;
    logic                pwr_we;
    logic                pwr_d;
    logic                clr_all;

    // Master power bit, on after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
        end else if (pwr_we) begin
            pwr_q <= pwr_d;
        end
    end

    // Synchronous sample of the channel-active flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 4'h0;
        end else begin
            stat_q <= chan_active;
        end
    end

    snd_write_gate #(.ADDR_W(ADDR_W), .LEGACY(LEGACY)) u_gate (
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .we      (bus_we),
        .pwr     (pwr_q),
        .ch_we   (ch_we),
        .ch_val  (ch_val),
        .pwr_we  (pwr_we),
        .pwr_d   (pwr_d),
        .clr_all (clr_all)
    );

    snd_reg_array u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_we    (ch_we),
        .ch_val   (ch_val),
        .clr_all  (clr_all),
        .cfg_flat (cfg_flat)
    );

    snd_read_mux #(.ADDR_W(ADDR_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .cfg_flat (cfg_flat),
        .pwr      (pwr_q),
        .stat     (stat_q),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/snd_ctl_bank_chk.sv
// Module: property checker for snd_ctl_bank, bound to every instance.
// Observes bus ports, the flat register bus and the power bit.
module snd_ctl_bank_chk #(
    parameter int ADDR_W = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [7:0]                bus_wdata,
    input logic                      bus_we,
    input logic [7:0]                bus_rdata,
    input logic [snd_pkg::CFG_W-1:0] cfg_flat,
    input logic                      pwr
);
    import snd_pkg::*;

    // R9: unimplemented addresses read all ones
    p_unimpl_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) >= 32'(N_IMPL)) |=> (bus_rdata == 8'hFF));

    // R9: writes to unimplemented addresses leave storage alone
    p_unimpl_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) >= 32'(N_IMPL)) |=> $stable(cfg_flat));

    // R7: master read shows ones in bits 6:4
    p_master_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) == 32'(MASTER_IDX)) |=> (bus_rdata[6:4] == 3'b111));

    // R8: power-off write clears every channel register
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == 32'(MASTER_IDX) && !bus_wdata[7]) |=> (cfg_flat == '0));

    // R4: envelope write while unpowered stores zero
    p_gated_env_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !pwr && bus_addr == ADDR_W'(2)) |=> (cfg_flat[23:16] == 8'h00));

    // R3: period-low always reads all ones
    p_mask_flo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(3)) |=> (bus_rdata == 8'hFF));
endmodule

bind snd_ctl_bank snd_ctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .cfg_flat  (cfg_flat),
    .pwr       (pwr_q)
);

// File: tb/sim_snd_ctl_bank.sv
// Bench: scoreboard with queued expected reads.
// Drives a legacy instance (u0) and an enhanced instance (u1) with shared stimulus.
module sim_snd_ctl_bank;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic          we;
    logic [3:0]    chan;
    logic [7:0]    rd0, rd1;
    logic [159:0]  cfg0, cfg1;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int         dut;
        logic [7:0] exp;
        int         due;
        string      tag;
    } item_t;
    item_t q[$];

    always #10 clk = ~clk;                  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    snd_ctl_bank #(.ADDR_W(AW), .LEGACY(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .chan_active(chan), .bus_rdata(rd0), .cfg_flat(cfg0));
    snd_ctl_bank #(.ADDR_W(AW), .LEGACY(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
        .chan_active(chan), .bus_rdata(rd1), .cfg_flat(cfg1));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: pops due items at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            chk($sformatf("%s dut%0d", it.tag, it.dut), (it.dut == 0) ? rd0 : rd1, it.exp);
        end
    end

    task automatic push(input int d, input logic [7:0] e, input string tag);
        item_t it;
        it.dut = d; it.exp = e; it.due = cyc + 1; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e0, input logic [7:0] e1,
                      input string tag);
        addr = a;
        push(0, e0, tag);
        push(1, e1, tag);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [159:0] snap;
        rst_n = 1'b0; we = 1'b0; addr = '0; wdata = 8'h00; chan = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 rdata reset", rd0, 8'hFF);
        chk("R1 cfg idx3 reset", cfg0[31:24], 8'hF3);
        chk("R1 cfg idx10 reset", cfg1[87:80], 8'hFF);
        rd(5'd0, 8'h80, 8'h80, "R1 sweep");
        rd(5'd1, 8'hBF, 8'hBF, "R1 ch1 length");
        rd(5'd2, 8'hF3, 8'hF3, "R1 envelope");
        rd(5'd18, 8'h77, 8'h77, "R1 volume");
        rd(5'd19, 8'hF3, 8'hF3, "R1 panning");
        rd(5'd20, 8'hF0, 8'hF0, "R1 master");

        // Powered writes and masks
        wr(5'd2, 8'h5A);  rd(5'd2, 8'h5A, 8'h5A, "R2 envelope");
        wr(5'd3, 8'h5A);  rd(5'd3, 8'hFF, 8'hFF, "R3 period low");
        chk("R2 period low stored", cfg0[31:24], 8'h5A);
        wr(5'd0, 8'h15);  rd(5'd0, 8'h95, 8'h95, "R3 sweep");
        wr(5'd4, 8'h07);  rd(5'd4, 8'hBF, 8'hBF, "R3 period high");
        wr(5'd11, 8'h20); rd(5'd11, 8'hBF, 8'hBF, "R3 level");
        wr(5'd9, 8'h00);  rd(5'd9, 8'h7F, 8'h7F, "R3 dac enable");

        // Master: only bit 7 kept, status from input
        chan = 4'b1010;
        wr(5'd20, 8'hFF);
        rd(5'd20, 8'hFA, 8'hFA, "R7 master status");

        // Status path latency R10
        chan = 4'b0101;
        addr = 5'd20;
        push(0, 8'hFA, "R10 status first edge");
        @(negedge clk);
        push(0, 8'hF5, "R10 status second edge");
        @(negedge clk);

        // Power off: clear and gating
        wr(5'd20, 8'h0F);
        chk("R8 clear u0", (cfg0 == '0) ? 8'h01 : 8'h00, 8'h01);
        chk("R8 clear u1", (cfg1 == '0) ? 8'h01 : 8'h00, 8'h01);
        rd(5'd20, 8'h75, 8'h75, "R7 master off");
        rd(5'd18, 8'h00, 8'h00, "R8 volume cleared");
        wr(5'd2, 8'h44);
        chk("R4 envelope u0", cfg0[23:16], 8'h00);
        rd(5'd2, 8'h00, 8'h00, "R4 envelope read");
        wr(5'd1, 8'hC5);
        chk("R5 legacy square length", cfg0[15:8], 8'h05);
        chk("R5 enhanced square length", cfg1[15:8], 8'h00);
        wr(5'd10, 8'h9C);
        chk("R6 legacy wave length", cfg0[87:80], 8'h9C);
        chk("R6 enhanced wave length", cfg1[87:80], 8'h00);
        wr(5'd14, 8'h31);
        chk("R6 legacy noise length", cfg0[119:112], 8'h31);
        chk("R6 enhanced noise length", cfg1[119:112], 8'h00);

        // Power on again
        wr(5'd20, 8'h80);
        wr(5'd18, 8'h12);
        rd(5'd18, 8'h12, 8'h12, "R2 volume after power on");

        // Unimplemented addresses
        snap = cfg0;
        wr(5'd21, 8'h00);
        chk("R9 write ignored", (cfg0 == snap) ? 8'h01 : 8'h00, 8'h01);
        rd(5'd21, 8'hFF, 8'hFF, "R9 read 21");
        rd(5'd31, 8'hFF, 8'hFF, "R9 read 31");

        // Back-to-back reads on consecutive cycles R10
        rd(5'd2, 8'h00, 8'h00, "R10 back to back a");
        rd(5'd3, 8'hFF, 8'hFF, "R10 back to back b");
        rd(5'd18, 8'h12, 8'h12, "R10 back to back c");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule